// File: doc/BRIEF.md
# Cascadable Repeater Forwarding and Collision Core

This block is the central decision logic of a four-port 100 Mb/s repeater that can be chained with peer devices over a shared expansion bus and stacked with other hubs. Every local twisted-pair port supplies a receive-activity flag and a 5-bit code group each clock. The expansion bus supplies the same for traffic that originates elsewhere. The block picks the single active source and copies its code groups to every other destination. When more than one source anywhere in the cascade is active, it sends a fixed jam code group to all local ports.

Activity is shared with neighbours through active-low flags. Peer devices on the local expansion bus and remote hubs on the backplane report their receive activity to this block. This block reports its own activity and drives a shared collision line. Local, peer and remote activity are counted together, so a collision between ports on different devices makes every device jam. A per-port exclusion mask removes ports that upstream fault logic has shut down, partitioned or isolated. An excluded port can no longer act as a source, but it still receives traffic. All timing is relative to the 25 MHz reference clock `clk`, and reset is synchronous and active high.

Top module: `repeater_core`

## Requirements
- R1: While `rst` is high, and on the first clock after it, all `port_tx_en` bits and `exp_tx_en` are 0, `col_n` is 1 and every symbol output carries the idle code 5'b11111.
- R2: With exactly one non-excluded local port p active and nothing else active, one clock later every port except p has its `port_tx_en` bit set and carries p's code group. Port p is not enabled. `exp_tx_en` is 1 and `exp_tx_sym` carries p's code group.
- R3: With only `exp_rx_act` active, one clock later all local ports are enabled and carry `exp_rx_sym`, and `exp_tx_en` is 0.
- R4: `local_act_n` is combinational. It is 0 in the same cycle that any non-excluded local port is active, and 1 otherwise.
- R5: When the number of active sources is above one, the block jams. Local flags count as they are, while peer and hub flags count as sampled on the rising edge. When jamming, all `port_tx_en` bits are 1, every port symbol is `JAM_CODE` (default 5'b01011), and `exp_tx_en` is 0.
- R6: `col_n` is a register on the rising edge. It goes to 0 when the source count is above one and at least one local port is among the sources. When only peer or hub sources collide, it stays 1.
- R7: A low `stack_col_n`, sampled on the falling edge, causes a jam on the following rising edge without asserting `col_n`.
- R8: Once jamming has started, it continues while any activity remains, even if the count falls to one. It stops when all local, peer, hub, expansion and stack-collision activity is gone.
- R9: A port whose `port_excl` bit is 1 is ignored for source selection, for the source count and for `local_act_n`. It is still a destination.
- R10: When no destination is enabled, every `port_tx_sym` field and `exp_tx_sym` hold the idle code 5'b11111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| port_rx_act | input | NPORT | Receive activity per local port |
| port_rx_sym | input | NPORT*5 | Received code group per port, port i at bits [5i+4:5i] |
| port_excl | input | NPORT | Per-port exclusion from sourcing |
| exp_rx_act | input | 1 | Expansion bus carries incoming data |
| exp_rx_sym | input | 5 | Code group from the expansion bus |
| peer_act_n | input | NPEER | Active-low activity flags of peer devices |
| hub_act_n | input | NHUB | Active-low activity flags of remote hubs |
| stack_col_n | input | 1 | Active-low stack-wide collision, falling-edge sampled |
| port_tx_en | output | NPORT | Transmit enable per local port |
| port_tx_sym | output | NPORT*5 | Transmit code group per port |
| exp_tx_en | output | 1 | This device drives the expansion bus |
| exp_tx_sym | output | 5 | Code group driven to the expansion bus |
| local_act_n | output | 1 | Active-low local receive activity |
| col_n | output | 1 | Active-low collision involving a local port |

## Verification
The bench builds the block with its default widths: four ports, five peer flags and seven hub flags. Because of this, every source class can appear together in one run. A local port can collide with a peer, and a peer can collide with a hub with no local port involved. Each direction can then be checked against `col_n`. The default jam code is used, so jam symbols can be told apart from forwarded ones. Exclusion, the jam that lingers until all activity ends, and the falling-edge stack collision are each driven as separate scenarios.

// File: rtl/rep_pkg.sv
package rep_pkg;
    localparam int SYM_W = 5;
    typedef logic [SYM_W-1:0] sym_t;

    localparam sym_t IDLE_SYM    = 5'b11111;
    localparam sym_t DEFAULT_JAM = 5'b01011;

    typedef struct packed {
        logic jam;
        logic any_act;
        logic local_involved;
    } col_state_t;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/rep_remote_sync.sv
module rep_remote_sync #(
    parameter int NPEER = 5,
    parameter int NHUB  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPEER-1:0] peer_act_n,
    input  logic [NHUB-1:0]  hub_act_n,
    input  logic             stack_col_n,
    output logic [NPEER-1:0] peer_act,
    output logic [NHUB-1:0]  hub_act,
    output logic             stack_col
);
    always_ff @(posedge clk) begin
        if (rst) begin
            peer_act <= '0;
            hub_act  <= '0;
        end else begin
            peer_act <= ~peer_act_n;
            hub_act  <= ~hub_act_n;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) stack_col <= 1'b0;
        else     stack_col <= ~stack_col_n;
    end
endmodule

// File: rtl/rep_col_detect.sv
module rep_col_detect
    import rep_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int NPEER = 5,
    parameter int NHUB  = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] loc_act,
    input  logic [NPEER-1:0] peer_act,
    input  logic [NHUB-1:0]  hub_act,
    input  logic             stack_col,
    input  logic             exp_act,
    output logic             jam,
    output logic             col_n_q
);
    localparam int SRC_N = NPORT + NPEER + NHUB;
    localparam int CNT_W = $clog2(SRC_N + 1);

    logic [CNT_W-1:0] loc_cnt, total_cnt;
    logic             coll_now;
    logic             jam_q;
    col_state_t       st;

    always_comb begin
        loc_cnt   = CNT_W'($countones(loc_act));
        total_cnt = loc_cnt + CNT_W'($countones(peer_act)) + CNT_W'($countones(hub_act));
        coll_now  = (total_cnt > CNT_W'(1)) || stack_col;
        st.any_act        = (total_cnt != '0) || exp_act || stack_col;
        st.local_involved = (loc_cnt != '0) && (total_cnt > CNT_W'(1));
        st.jam            = coll_now || (jam_q && st.any_act);
    end

    assign jam = st.jam;

    always_ff @(posedge clk) begin
        if (rst) begin
            jam_q   <= 1'b0;
            col_n_q <= 1'b1;
        end else begin
            jam_q   <= st.jam;
            col_n_q <= ~st.local_involved;
        end
    end
endmodule

// File: rtl/rep_fwd_map.sv
module rep_fwd_map
    import rep_pkg::*;
#(
    parameter int   NPORT    = 4,
    parameter sym_t JAM_CODE = DEFAULT_JAM
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NPORT-1:0]   loc_act,
    input  logic [NPORT*5-1:0] port_rx_sym,
    input  logic               exp_rx_act,
    input  sym_t               exp_rx_sym,
    input  logic               jam,
    output logic [NPORT-1:0]   port_tx_en,
    output logic [NPORT*5-1:0] port_tx_sym,
    output logic               exp_tx_en,
    output sym_t               exp_tx_sym
);
    localparam int IDX_W = idx_width(NPORT);

    sym_t             rx_arr [NPORT];
    sym_t             tx_arr_d [NPORT];
    logic [NPORT-1:0] en_d;
    logic             xen_d;
    sym_t             xsym_d;
    logic             src_found;
    logic [IDX_W-1:0] src_idx;
    sym_t             src_sym;

    for (genvar g = 0; g < NPORT; g++) begin : g_unpack
        assign rx_arr[g] = port_rx_sym[g*5 +: 5];
    end

    always_comb begin
        src_found = 1'b0;
        src_idx   = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (loc_act[i] && !src_found) begin
                src_found = 1'b1;
                src_idx   = IDX_W'(i);
            end
        end
        src_sym = rx_arr[src_idx];
    end

    always_comb begin
        en_d   = '0;
        xen_d  = 1'b0;
        xsym_d = IDLE_SYM;
        for (int i = 0; i < NPORT; i++) tx_arr_d[i] = IDLE_SYM;
        if (jam) begin
            en_d = '1;
            for (int i = 0; i < NPORT; i++) tx_arr_d[i] = JAM_CODE;
        end else if (src_found) begin
            xen_d  = 1'b1;
            xsym_d = src_sym;
            for (int i = 0; i < NPORT; i++) begin
                if (IDX_W'(i) != src_idx) begin
                    en_d[i]     = 1'b1;
                    tx_arr_d[i] = src_sym;
                end
            end
        end else if (exp_rx_act) begin
            en_d = '1;
            for (int i = 0; i < NPORT; i++) tx_arr_d[i] = exp_rx_sym;
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_txreg
        always_ff @(posedge clk) begin
            if (rst) begin
                port_tx_en[g]        <= 1'b0;
                port_tx_sym[g*5 +: 5] <= IDLE_SYM;
            end else begin
                port_tx_en[g]        <= en_d[g];
                port_tx_sym[g*5 +: 5] <= tx_arr_d[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_tx_en  <= 1'b0;
            exp_tx_sym <= IDLE_SYM;
        end else begin
            exp_tx_en  <= xen_d;
            exp_tx_sym <= xsym_d;
        end
    end
endmodule

// File: rtl/repeater_core.sv
module repeater_core
    import rep_pkg::*;
#(
    parameter int   NPORT    = 4,
    parameter int   NPEER    = 5,
    parameter int   NHUB     = 7,
    parameter sym_t JAM_CODE = DEFAULT_JAM
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NPORT-1:0]   port_rx_act,
    input  logic [NPORT*5-1:0] port_rx_sym,
    input  logic [NPORT-1:0]   port_excl,
    input  logic               exp_rx_act,
    input  logic [4:0]         exp_rx_sym,
    input  logic [NPEER-1:0]   peer_act_n,
    input  logic [NHUB-1:0]    hub_act_n,
    input  logic               stack_col_n,
    output logic [NPORT-1:0]   port_tx_en,
    output logic [NPORT*5-1:0] port_tx_sym,
    output logic               exp_tx_en,
    output logic [4:0]         exp_tx_sym,
    output logic               local_act_n,
    output logic               col_n
);
    logic [NPORT-1:0] loc_act;
    logic [NPEER-1:0] peer_act;
    logic [NHUB-1:0]  hub_act;
    logic             stack_col;
    logic             jam;

    assign loc_act     = port_rx_act & ~port_excl;
    assign local_act_n = ~|loc_act;

    rep_remote_sync #(.NPEER(NPEER), .NHUB(NHUB)) u_sync (
        .clk(clk), .rst(rst),
        .peer_act_n(peer_act_n), .hub_act_n(hub_act_n), .stack_col_n(stack_col_n),
        .peer_act(peer_act), .hub_act(hub_act), .stack_col(stack_col)
    );

    rep_col_detect #(.NPORT(NPORT), .NPEER(NPEER), .NHUB(NHUB)) u_col (
        .clk(clk), .rst(rst),
        .loc_act(loc_act), .peer_act(peer_act), .hub_act(hub_act),
        .stack_col(stack_col), .exp_act(exp_rx_act),
        .jam(jam), .col_n_q(col_n)
    );

    rep_fwd_map #(.NPORT(NPORT), .JAM_CODE(JAM_CODE)) u_fwd (
        .clk(clk), .rst(rst),
        .loc_act(loc_act), .port_rx_sym(port_rx_sym),
        .exp_rx_act(exp_rx_act), .exp_rx_sym(exp_rx_sym), .jam(jam),
        .port_tx_en(port_tx_en), .port_tx_sym(port_tx_sym),
        .exp_tx_en(exp_tx_en), .exp_tx_sym(exp_tx_sym)
    );
endmodule

// File: rtl/rep_core_chk.sv
module rep_core_chk
    import rep_pkg::*;
#(
    parameter int NPORT = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [NPORT-1:0]   port_tx_en,
    input logic [NPORT*5-1:0] port_tx_sym,
    input logic               exp_tx_en,
    input logic               local_act_n,
    input logic               col_n
);
    // R1: registered outputs are quiet right after a reset cycle
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (port_tx_en == '0 && !exp_tx_en && col_n));

    // R2: a local source never echoes to itself
    p_no_echo_r2: assert property (@(posedge clk) disable iff (rst)
        exp_tx_en |-> ($countones(port_tx_en) == NPORT - 1));

    // R5: a local collision always jams every port and releases the bus
    p_col_jams_r5: assert property (@(posedge clk) disable iff (rst)
        !col_n |-> (port_tx_en == '1 && !exp_tx_en));

    // R6: collision output needs local activity in the previous cycle
    p_col_local_r6: assert property (@(posedge clk) disable iff (rst)
        !col_n |-> ($past(local_act_n) == 1'b0));

    // R10: idle code on every field when no port is enabled
    p_idle_sym_r10: assert property (@(posedge clk) disable iff (rst)
        (port_tx_en == '0) |-> (port_tx_sym == {NPORT{IDLE_SYM}}));
endmodule

bind repeater_core rep_core_chk #(.NPORT(NPORT)) u_chk (
    .clk(clk), .rst(rst), .port_tx_en(port_tx_en), .port_tx_sym(port_tx_sym),
    .exp_tx_en(exp_tx_en), .local_act_n(local_act_n), .col_n(col_n)
);

// File: tb/sim_repeater_core.sv
module sim_repeater_core;
    localparam int CLK_PERIOD = 40;
    localparam int NPORT = 4;
    localparam int NPEER = 5;
    localparam int NHUB  = 7;
    localparam logic [4:0] IDLE = 5'b11111;
    localparam logic [4:0] JAM  = 5'b01011;

    logic               clk = 1'b0;
    logic               rst;
    logic [NPORT-1:0]   port_rx_act;
    logic [NPORT*5-1:0] port_rx_sym;
    logic [NPORT-1:0]   port_excl;
    logic               exp_rx_act;
    logic [4:0]         exp_rx_sym;
    logic [NPEER-1:0]   peer_act_n;
    logic [NHUB-1:0]    hub_act_n;
    logic               stack_col_n;
    logic [NPORT-1:0]   port_tx_en;
    logic [NPORT*5-1:0] port_tx_sym;
    logic               exp_tx_en;
    logic [4:0]         exp_tx_sym;
    logic               local_act_n;
    logic               col_n;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    repeater_core u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic quiet();
        port_rx_act = '0; port_rx_sym = '0; port_excl = '0;
        exp_rx_act = 1'b0; exp_rx_sym = '0;
        peer_act_n = '1; hub_act_n = '1; stack_col_n = 1'b1;
    endtask

    task automatic drive_edge();
        @(posedge clk); #1;
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        quiet(); rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_eq("R1 tx_en", 32'(port_tx_en), 0);
        chk_eq("R1 exp_tx_en", 32'(exp_tx_en), 0);
        chk_eq("R1 col_n", 32'(col_n), 1);
        chk_eq("R1 idle syms", 32'(port_tx_sym), 32'({NPORT{IDLE}}));
        chk_eq("R1 exp sym", 32'(exp_tx_sym), 32'(IDLE));
        drive_edge(); rst = 1'b0;
    endtask

    task automatic t_single_local();
        drive_edge(); quiet();
        port_rx_act[2] = 1'b1; port_rx_sym[10 +: 5] = 5'h0E;
        #1 chk_eq("R4 local_act_n same cycle", 32'(local_act_n), 0);
        settle();
        chk_eq("R2 tx_en", 32'(port_tx_en), 32'b1011);
        chk_eq("R2 port3 sym", 32'(port_tx_sym[15 +: 5]), 32'h0E);
        chk_eq("R2 port0 sym", 32'(port_tx_sym[0 +: 5]), 32'h0E);
        chk_eq("R2 exp_tx_en", 32'(exp_tx_en), 1);
        chk_eq("R2 exp sym", 32'(exp_tx_sym), 32'h0E);
        chk_eq("R2 col_n", 32'(col_n), 1);
    endtask

    task automatic t_expansion();
        drive_edge(); quiet();
        exp_rx_act = 1'b1; exp_rx_sym = 5'h15;
        settle();
        chk_eq("R3 tx_en", 32'(port_tx_en), 32'b1111);
        chk_eq("R3 port1 sym", 32'(port_tx_sym[5 +: 5]), 32'h15);
        chk_eq("R3 exp_tx_en", 32'(exp_tx_en), 0);
        chk_eq("R4 local_act_n idle", 32'(local_act_n), 1);
    endtask

    task automatic t_local_collision();
        drive_edge(); quiet();
        port_rx_act = 4'b1001; port_rx_sym = {5'h07, 5'h00, 5'h00, 5'h0E};
        settle();
        chk_eq("R5 tx_en", 32'(port_tx_en), 32'b1111);
        chk_eq("R5 jam syms", 32'(port_tx_sym), 32'({NPORT{JAM}}));
        chk_eq("R5 exp_tx_en", 32'(exp_tx_en), 0);
        chk_eq("R6 col_n local", 32'(col_n), 0);
    endtask

    task automatic t_peer_collision();
        drive_edge(); quiet();
        port_rx_act[1] = 1'b1; port_rx_sym[5 +: 5] = 5'h09; peer_act_n[2] = 1'b0;
        settle();
        chk_eq("R5 cross-device jam", 32'(port_tx_sym), 32'({NPORT{JAM}}));
        chk_eq("R6 col_n cross-device", 32'(col_n), 0);
    endtask

    task automatic t_remote_only();
        drive_edge(); quiet();
        peer_act_n[0] = 1'b0; hub_act_n[3] = 1'b0; exp_rx_act = 1'b1; exp_rx_sym = 5'h15;
        settle();
        chk_eq("R5 remote jam", 32'(port_tx_sym), 32'({NPORT{JAM}}));
        chk_eq("R6 col_n remote only", 32'(col_n), 1);
    endtask

    task automatic t_stack_col();
        drive_edge(); quiet();
        stack_col_n = 1'b0;
        settle();
        chk_eq("R7 tx_en", 32'(port_tx_en), 32'b1111);
        chk_eq("R7 jam syms", 32'(port_tx_sym), 32'({NPORT{JAM}}));
        chk_eq("R7 col_n", 32'(col_n), 1);
    endtask

    task automatic t_sticky();
        drive_edge(); quiet();
        port_rx_act = 4'b0011; port_rx_sym = {5'h00, 5'h00, 5'h0C, 5'h0D};
        settle();
        drive_edge(); port_rx_act = 4'b0001;
        settle();
        chk_eq("R8 jam held", 32'(port_tx_sym), 32'({NPORT{JAM}}));
        chk_eq("R8 exp released", 32'(exp_tx_en), 0);
        drive_edge(); quiet();
        settle();
        chk_eq("R8 jam ends", 32'(port_tx_en), 0);
        chk_eq("R10 idle syms", 32'(port_tx_sym), 32'({NPORT{IDLE}}));
        chk_eq("R10 exp idle", 32'(exp_tx_sym), 32'(IDLE));
    endtask

    task automatic t_excluded();
        drive_edge(); quiet();
        port_excl = 4'b0010; port_rx_act = 4'b0011;
        port_rx_sym = {5'h00, 5'h00, 5'h1A, 5'h07};
        settle();
        chk_eq("R9 tx_en", 32'(port_tx_en), 32'b1110);
        chk_eq("R9 port1 sym", 32'(port_tx_sym[5 +: 5]), 32'h07);
        chk_eq("R9 col_n", 32'(col_n), 1);
        drive_edge(); port_rx_act = 4'b0010;
        #1 chk_eq("R9 R4 local_act_n", 32'(local_act_n), 1);
        settle();
        chk_eq("R9 no source", 32'(port_tx_en), 0);
    endtask

    initial begin
        t_reset();
        t_single_local();
        t_expansion();
        t_local_collision();
        t_peer_collision();
        t_remote_only();
        t_stack_col();
        t_sticky();
        t_excluded();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule